// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a memory-mapped watchdog that guards its own configuration. Software talks to it through four word registers: a mode register, a timeout-length register, a restart register and a software-reset register. No write changes anything unless it carries the key that belongs to its register. A wrong key, or a wrong command word, leaves every piece of state as it was. Reads return the stored fields with the key bits cleared.

The countdown advances on a slow tick strobe, which is nominally 32 kHz. The programmed timeout is counted in units of 512 ticks, so one second is 64 units and the longest timeout, 31 seconds, is 1984 units. When the countdown runs out, the block can do one of three things, chosen in the mode register. It can pulse an external reset pin at a programmable polarity. It can raise an interrupt. In dual mode it interrupts first and resets on a second expiry. A keyed software-reset command pulses the reset pin at once.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the mode register reads 0, the length register reads 0x0000F800 (1984 units), `rst_out` sits at its idle level 1 and `irq_out` is 0.
- R2: A write to offset 0x00 is taken only when bits [31:24] equal 0x22. The stored fields are bit 0 run, bit 1 polarity (1 = reset active high), bit 2 reset-pin enable, bit 3 interrupt enable, bit 4 auto start and bit 6 dual mode. A read returns only these bits, and every other bit reads 0.
- R3: A write to offset 0x04 is taken only when bits [4:0] equal 0x08. The timeout in units sits in bits [15:5]. A value above 1984 is stored as 1984, and a read returns units << 5.
- R4: Each of the following has no effect on any state or output: a mode write with a bad key, a length write with a bad key, a restart write of any word other than 0x1971, and a software-reset write of any word other than 0x1209.
- R5: Writing 0x1971 to offset 0x08 loads the countdown with units × 512 ticks. A keyed length write on its own does not reload the countdown.
- R6: With run set, the countdown expires on the units × 512-th tick after a reload and then reloads itself. With run clear, ticks do not advance it.
- R7: With the interrupt and dual bits clear and the reset-pin enable set, an expiry drives `rst_out` to the level of the polarity bit for 16 cycles, starting the cycle after the expiring tick.
- R8: With the reset-pin enable clear, an expiry leaves `rst_out` at its idle level.
- R9: With the interrupt bit set and dual clear, an expiry raises `irq_out` and does not pulse the reset pin. `irq_out` then holds until a valid restart write clears it.
- R10: In dual mode the first expiry raises `irq_out`. An expiry while `irq_out` is still high pulses the reset pin, provided the reset-pin enable is set.
- R11: Writing 0x1209 to offset 0x14 starts a 16-cycle reset pulse on the next edge. This happens whatever the run, reset-pin-enable and interrupt bits hold.
- R12: With auto start set, a valid restart write also sets the run bit.
- R13: A timeout of 0 units expires on the first tick after a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe from the slow timebase |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write word, including its key |
| bus_rdata | output | 32 | Readback of the register at `bus_addr` |
| rst_out | output | 1 | External reset pin, level set by the polarity bit |
| irq_out | output | 1 | Watchdog interrupt |

## Verification
The assertions check these properties on every cycle:
- a software-reset command always starts the pulse;
- a reload places units × 512 into the countdown;
- a stopped countdown never moves;
- a badly keyed mode write never alters the mode;
- the interrupt rises only after an expiry;
- a disabled reset pin stays idle across an expiry.

Some behaviour shows only in the bench's scenarios:
- the exact expiry distance after a restart;
- the 16-cycle pulse width;
- dual-mode escalation;
- auto start;
- the zero-length corner.

The bench's behavioural model is compared against the readback, the pin and the interrupt on every clock.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

  // byte offsets of the register slots
  localparam int OFS_MODE  = 'h00;
  localparam int OFS_LEN   = 'h04;
  localparam int OFS_KICK  = 'h08;
  localparam int OFS_SWRST = 'h14;

  // keys and command words
  localparam logic [7:0]  MODE_KEY_BYTE = 8'h22;
  localparam logic [4:0]  LEN_KEY       = 5'h08;
  localparam logic [31:0] KICK_WORD     = 32'h0000_1971;
  localparam logic [31:0] SWRST_WORD    = 32'h0000_1209;
  localparam int          LEN_FIELD_LSB = 5;

  // mode bit positions (software visible)
  localparam int B_RUN  = 0;
  localparam int B_POL  = 1;
  localparam int B_EXT  = 2;
  localparam int B_IRQ  = 3;
  localparam int B_AUTO = 4;
  localparam int B_DUAL = 6;

  typedef struct packed {
    logic dual;
    logic auto_go;
    logic irq_en;
    logic ext_en;
    logic pol_hi;
    logic run;
  } mode_t;

  function automatic logic mode_key_ok(input logic [31:0] w);
    return w[31:24] == MODE_KEY_BYTE;
  endfunction

  function automatic logic len_key_ok(input logic [31:0] w);
    return w[LEN_FIELD_LSB-1:0] == LEN_KEY;
  endfunction

  function automatic mode_t word_to_mode(input logic [31:0] w);
    mode_t m;
    m.run     = w[B_RUN];
    m.pol_hi  = w[B_POL];
    m.ext_en  = w[B_EXT];
    m.irq_en  = w[B_IRQ];
    m.auto_go = w[B_AUTO];
    m.dual    = w[B_DUAL];
    return m;
  endfunction

  function automatic logic [31:0] mode_to_word(input mode_t m);
    logic [31:0] w;
    w         = '0;
    w[B_RUN]  = m.run;
    w[B_POL]  = m.pol_hi;
    w[B_EXT]  = m.ext_en;
    w[B_IRQ]  = m.irq_en;
    w[B_AUTO] = m.auto_go;
    w[B_DUAL] = m.dual;
    return w;
  endfunction

  // pin level for a given pulse state and polarity
  function automatic logic pin_level(input logic active, input logic pol_hi);
    return pol_hi ? active : ~active;
  endfunction

endpackage

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int LEN_W     = 11,
  parameter int MAX_UNITS = 1984
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output mode_t             mode_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              kick_evt,
  output logic              swrst_evt,
  output logic [31:0]       bus_rdata
);

  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(OFS_LEN);
  localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFS_KICK);
  localparam logic [ADDR_W-1:0] A_SWRST = ADDR_W'(OFS_SWRST);
  localparam logic [LEN_W-1:0]  LEN_MAX = LEN_W'(MAX_UNITS);

  function automatic logic [LEN_W-1:0] clamp_units(input logic [LEN_W-1:0] v);
    return (v > LEN_MAX) ? LEN_MAX : v;
  endfunction

  logic             mode_wr_ok;
  logic             len_wr_ok;
  logic [LEN_W-1:0] len_field;

  assign mode_wr_ok = bus_we && (bus_addr == A_MODE) && mode_key_ok(bus_wdata);
  assign len_wr_ok  = bus_we && (bus_addr == A_LEN)  && len_key_ok(bus_wdata);
  assign len_field  = bus_wdata[LEN_FIELD_LSB +: LEN_W];
  assign kick_evt   = bus_we && (bus_addr == A_KICK)  && (bus_wdata == KICK_WORD);
  assign swrst_evt  = bus_we && (bus_addr == A_SWRST) && (bus_wdata == SWRST_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      len_q  <= LEN_MAX;
    end else begin
      if (mode_wr_ok)
        mode_q <= word_to_mode(bus_wdata);
      else if (kick_evt && mode_q.auto_go)
        mode_q.run <= 1'b1;
      if (len_wr_ok)
        len_q <= clamp_units(len_field);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:  bus_rdata = mode_to_word(mode_q);
      A_LEN:   bus_rdata = 32'(len_q) << LEN_FIELD_LSB;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/keyed_wdog_countdown.sv
module keyed_wdog_countdown #(
  parameter int LEN_W          = 11,
  parameter int CNT_W          = 20,
  parameter int TICKS_PER_UNIT = 512,
  parameter int MAX_UNITS      = 1984
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             kick,
  input  logic [LEN_W-1:0] len_units,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);

  localparam bit UNIT_POW2  = (TICKS_PER_UNIT & (TICKS_PER_UNIT - 1)) == 0;
  localparam int UNIT_SHIFT = $clog2(TICKS_PER_UNIT);
  localparam logic [CNT_W-1:0] CNT_RESET = CNT_W'(MAX_UNITS * TICKS_PER_UNIT);

  logic [CNT_W-1:0] reload_ticks;

  generate
    if (UNIT_POW2) begin : g_shift
      assign reload_ticks = CNT_W'(len_units) << UNIT_SHIFT;
    end else begin : g_mult
      assign reload_ticks = CNT_W'(len_units) * CNT_W'(TICKS_PER_UNIT);
    end
  endgenerate

  logic last_tick;
  assign last_tick = cnt_q <= CNT_W'(1);
  assign expire    = run && tick && !kick && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= CNT_RESET;
    else if (kick || expire)
      cnt_q <= reload_ticks;
    else if (run && tick)
      cnt_q <= cnt_q - CNT_W'(1);
  end

endmodule

// File: rtl/keyed_wdog_response.sv
module keyed_wdog_response
  import keyed_wdog_pkg::*;
#(
  parameter int PULSE_CYCLES = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode_q,
  input  logic  expire,
  input  logic  swrst_evt,
  input  logic  kick_evt,
  output logic  irq_q,
  output logic  fire_rst,
  output logic  rst_active
);

  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic [PW-1:0] pulse_left;
  logic          tmo_reset;
  logic          tmo_irq;

  // dual mode escalates only with an interrupt still pending
  assign tmo_reset  = expire && mode_q.ext_en && (mode_q.dual ? irq_q : !mode_q.irq_en);
  assign tmo_irq    = expire && (mode_q.irq_en || mode_q.dual);
  assign fire_rst   = swrst_evt || tmo_reset;
  assign rst_active = pulse_left != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_left <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (fire_rst)
        pulse_left <= PW'(PULSE_CYCLES);
      else if (rst_active)
        pulse_left <= pulse_left - PW'(1);
      if (kick_evt)
        irq_q <= 1'b0;
      else if (tmo_irq)
        irq_q <= 1'b1;
    end
  end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W         = 5,
  parameter int TICKS_PER_UNIT = 512,
  parameter int UNITS_PER_SEC  = 64,
  parameter int MAX_SEC        = 31,
  parameter int PULSE_CYCLES   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_out,
  output logic              irq_out
);

  localparam int MAX_UNITS = MAX_SEC * UNITS_PER_SEC;
  localparam int LEN_W     = $clog2(MAX_UNITS + 1);
  localparam int CNT_W     = $clog2(MAX_UNITS * TICKS_PER_UNIT + 1);

  mode_t            mode_q;
  logic [LEN_W-1:0] len_q;
  logic             kick_evt;
  logic             swrst_evt;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;
  logic             fire_rst;
  logic             rst_active;

  keyed_wdog_regs #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .MAX_UNITS(MAX_UNITS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .mode_q   (mode_q),
    .len_q    (len_q),
    .kick_evt (kick_evt),
    .swrst_evt(swrst_evt),
    .bus_rdata(bus_rdata)
  );

  keyed_wdog_countdown #(
    .LEN_W         (LEN_W),
    .CNT_W         (CNT_W),
    .TICKS_PER_UNIT(TICKS_PER_UNIT),
    .MAX_UNITS     (MAX_UNITS)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (mode_q.run),
    .tick     (tick),
    .kick     (kick_evt),
    .len_units(len_q),
    .cnt_q    (cnt_q),
    .expire   (expire)
  );

  keyed_wdog_response #(
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .expire    (expire),
    .swrst_evt (swrst_evt),
    .kick_evt  (kick_evt),
    .irq_q     (irq_out),
    .fire_rst  (fire_rst),
    .rst_active(rst_active)
  );

  assign rst_out = pin_level(rst_active, mode_q.pol_hi);

endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W         = 5,
  parameter int LEN_W          = 11,
  parameter int CNT_W          = 20,
  parameter int TICKS_PER_UNIT = 512,
  parameter int MAX_UNITS      = 1984
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input mode_t             mode_q,
  input logic [LEN_W-1:0]  len_q,
  input logic              kick_evt,
  input logic              swrst_evt,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              expire,
  input logic              rst_active,
  input logic              irq_out
);

  // R11
  swrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_evt |=> rst_active);

  // R8
  ext_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mode_q.ext_en && !swrst_evt && !rst_active) |=> !rst_active);

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(expire));

  // R5
  kick_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_evt |=> (cnt_q == CNT_W'($past(len_q)) * CNT_W'(TICKS_PER_UNIT)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q.run && !kick_evt) |=> $stable(cnt_q));

  // R4
  mode_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_MODE) && bus_wdata[31:24] != MODE_KEY_BYTE)
      |=> $stable(mode_q));

  // R3
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_W'(MAX_UNITS));

  // R2
  key_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_MODE)) |-> (bus_rdata[31:7] == '0 && !bus_rdata[5]));

endmodule

bind keyed_wdog keyed_wdog_chk #(
  .ADDR_W        (ADDR_W),
  .LEN_W         (LEN_W),
  .CNT_W         (CNT_W),
  .TICKS_PER_UNIT(TICKS_PER_UNIT),
  .MAX_UNITS     (MAX_UNITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .mode_q    (mode_q),
  .len_q     (len_q),
  .kick_evt  (kick_evt),
  .swrst_evt (swrst_evt),
  .cnt_q     (cnt_q),
  .expire    (expire),
  .rst_active(rst_active),
  .irq_out   (irq_out)
);

// File: tb/keyed_wdog_test.sv
`timescale 1ns/1ps
module keyed_wdog_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = 5'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        rst_out;
  logic        irq_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keyed_wdog uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_out(rst_out), .irq_out(irq_out)
  );

  // ---------------- behavioural reference model ----------------
  int m_en, m_pol, m_ext, m_irqen, m_auto, m_dual;
  int m_len, m_left, m_irq, m_pulse;

  always @(posedge clk) begin
    int kick, sw, ex, fire, v;
    if (!rst_n) begin
      m_en = 0; m_pol = 0; m_ext = 0; m_irqen = 0; m_auto = 0; m_dual = 0;
      m_len = 1984; m_left = 1984 * 512; m_irq = 0; m_pulse = 0;
    end else begin
      kick = (bus_we && bus_addr == 5'h08 && bus_wdata == 32'h1971) ? 1 : 0;
      sw   = (bus_we && bus_addr == 5'h14 && bus_wdata == 32'h1209) ? 1 : 0;
      ex   = (m_en != 0 && tick && kick == 0 && m_left <= 1) ? 1 : 0;
      fire = sw;
      if (ex != 0 && m_ext != 0) begin
        if (m_dual != 0) begin
          if (m_irq != 0) fire = 1;
        end else if (m_irqen == 0) fire = 1;
      end
      if (fire != 0) m_pulse = 16;
      else if (m_pulse > 0) m_pulse = m_pulse - 1;
      if (kick != 0) m_irq = 0;
      else if (ex != 0 && (m_irqen != 0 || m_dual != 0)) m_irq = 1;
      if (kick != 0 || ex != 0) m_left = m_len * 512;
      else if (m_en != 0 && tick) m_left = m_left - 1;
      if (bus_we && bus_addr == 5'h00 && bus_wdata[31:24] == 8'h22) begin
        m_en = bus_wdata[0]; m_pol = bus_wdata[1]; m_ext = bus_wdata[2];
        m_irqen = bus_wdata[3]; m_auto = bus_wdata[4]; m_dual = bus_wdata[6];
      end else if (kick != 0 && m_auto != 0) m_en = 1;
      if (bus_we && bus_addr == 5'h04 && bus_wdata[4:0] == 5'h08) begin
        v = int'(bus_wdata[15:5]);
        m_len = (v > 1984) ? 1984 : v;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    int exp_rd, exp_pin;
    #2;
    if (rst_n && !done) begin
      exp_rd = 0;
      if (bus_addr == 5'h00)
        exp_rd = (m_dual << 6) | (m_auto << 4) | (m_irqen << 3) | (m_ext << 2) | (m_pol << 1) | m_en;
      else if (bus_addr == 5'h04)
        exp_rd = m_len << 5;
      exp_pin = (m_pulse > 0) ? m_pol : 1 - m_pol;
      chk(int'(bus_rdata) == exp_rd, "R2 model readback", int'(bus_rdata), exp_rd);
      chk(int'(rst_out) == exp_pin, "R7 model reset pin", int'(rst_out), exp_pin);
      chk(int'(irq_out) == m_irq, "R9 model interrupt", int'(irq_out), m_irq);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic rd(input logic [4:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = int'(bus_rdata);
  endtask

  // cycles until rst_out shows the given level, max bounded
  task automatic wait_pin(input logic lvl, input int lim, output int n);
    bit hit;
    n = 0; hit = 0;
    while (!hit && n < lim) begin
      @(negedge clk); n++; #1;
      if (rst_out == lvl) hit = 1;
    end
  endtask

  // cycles during which rst_out shows the given level over a window
  task automatic count_pin(input logic lvl, input int win, output int n);
    n = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk); #1;
      if (rst_out == lvl) n++;
    end
  endtask

  // watchdog for the run itself
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int d, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, d); chk(d == 0, "R1 mode after reset", d, 0);
    rd(5'h04, d); chk(d == 32'hF800, "R1 length after reset", d, 32'hF800);
    chk(rst_out == 1'b1, "R1 pin idle", int'(rst_out), 1);
    chk(irq_out == 1'b0, "R1 irq idle", int'(irq_out), 0);

    // R2 keyed mode write, key and stray bits dropped on readback
    wr(5'h00, 32'h22AB_CD7E);
    rd(5'h00, d); chk(d == 32'h5E, "R2 mode fields", d, 32'h5E);
    wr(5'h00, 32'h2200_0000);
    rd(5'h00, d); chk(d == 0, "R2 mode cleared", d, 0);

    // R4 bad keys and bad command words
    wr(5'h00, 32'h2300_0005);
    rd(5'h00, d); chk(d == 0, "R4 mode bad key", d, 0);
    wr(5'h04, 32'h0000_0029);
    rd(5'h04, d); chk(d == 32'hF800, "R4 length bad key", d, 32'hF800);
    wr(5'h14, 32'h0000_1208);
    count_pin(1'b0, 20, n); chk(n == 0, "R4 bad reset word", n, 0);

    // R3 length field and clamp
    wr(5'h04, (32'd3 << 5) | 32'h8);
    rd(5'h04, d); chk(d == 32'h60, "R3 length 3 units", d, 32'h60);
    wr(5'h04, (32'd2000 << 5) | 32'h8);
    rd(5'h04, d); chk(d == 32'hF800, "R3 length clamp", d, 32'hF800);

    // R5 length write alone does not reload; then restart does
    wr(5'h00, 32'h2200_0005);
    wr(5'h04, (32'd1 << 5) | 32'h8);
    count_pin(1'b0, 600, n); chk(n == 0, "R5 no reload from length", n, 0);
    wr(5'h08, 32'h1970);
    count_pin(1'b0, 600, n); chk(n == 0, "R4 bad restart word", n, 0);
    wr(5'h08, 32'h1971);
    wait_pin(1'b0, 700, n); chk(n == 512, "R6 expiry distance", n, 512);
    count_pin(1'b0, 20, d); chk(d == 15, "R7 pulse width", d + 1, 16);
    wr(5'h00, 32'h2200_0004);

    // R6 stopped countdown: no expiry while run is clear
    wr(5'h08, 32'h1971);
    count_pin(1'b0, 1200, n); chk(n == 0, "R6 hold while stopped", n, 0);

    // R8 reset pin disabled
    wr(5'h00, 32'h2200_0001);
    wr(5'h08, 32'h1971);
    count_pin(1'b0, 600, n); chk(n == 0, "R8 pin stays idle", n, 0);
    chk(irq_out == 1'b0, "R8 no irq", int'(irq_out), 0);
    wr(5'h00, 32'h2200_0000);

    // R9 interrupt only
    wr(5'h00, 32'h2200_000D);
    wr(5'h08, 32'h1971);
    count_pin(1'b0, 1100, n); chk(n == 0, "R9 no reset in irq mode", n, 0);
    chk(irq_out == 1'b1, "R9 irq held", int'(irq_out), 1);
    wr(5'h08, 32'h1971);
    #1; chk(irq_out == 1'b0, "R9 irq cleared by restart", int'(irq_out), 0);
    wr(5'h00, 32'h2200_0000);

    // R10 dual mode, active-high pin
    wr(5'h00, 32'h2200_0047);
    #1; chk(rst_out == 1'b0, "R10 idle level high polarity", int'(rst_out), 0);
    wr(5'h08, 32'h1971);
    wait_pin(1'b1, 1200, n); chk(n == 1024, "R10 escalation distance", n, 1024);
    chk(irq_out == 1'b1, "R10 irq pending at reset", int'(irq_out), 1);
    wr(5'h00, 32'h2200_0000);
    wr(5'h08, 32'h1971);
    repeat (20) @(negedge clk);

    // R11 software reset with everything else off
    wr(5'h14, 32'h1209);
    #1; chk(rst_out == 1'b0, "R11 immediate pulse", int'(rst_out), 0);
    count_pin(1'b0, 20, n); chk(n == 15, "R11 pulse width", n + 1, 16);

    // R12 auto start
    wr(5'h00, 32'h2200_0010);
    rd(5'h00, d); chk(d == 32'h10, "R12 before restart", d, 32'h10);
    wr(5'h08, 32'h1971);
    rd(5'h00, d); chk(d == 32'h11, "R12 run set by restart", d, 32'h11);
    wr(5'h00, 32'h2200_0000);

    // R13 zero-length timeout
    wr(5'h04, 32'h0000_0008);
    wr(5'h08, 32'h1971);
    wr(5'h00, 32'h2200_0004);
    wr(5'h00, 32'h2200_0005);
    wr(5'h08, 32'h1971);
    wait_pin(1'b0, 10, n); chk(n == 1, "R13 zero units", n, 1);
    wr(5'h00, 32'h2200_0004);
    repeat (24) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule